// File: doc/BRIEF.md
# Audio Link Global Status Register

This block holds the 16-bit global status word of a controller that talks to one or two audio or modem codecs over a serial link. Four event bits latch and stay set until software clears them. These are the codec-read time-out, one resume flag for each serial data input, and a general-purpose-input change flag. The other bits are not stored: they show the codec-ready levels and the per-channel interrupt summaries live. Three more bits hold a copy of the most recent slot 12 status nibble.

The bus side reads the word at any time. Software clears an event bit by writing a 1 to it in an enabled byte lane. A write that crosses a 32-bit boundary is flagged as such by the bus and changes nothing. The block has two synchronous, active-low resets. The main reset clears all stored state. The power-state-return reset clears only the captured slot 12 copy, so the event bits survive it.

Top module: `glsts_status`

## Requirements
- R1: Bit 15 becomes 1 one cycle after a cycle in which `rd_timeout` is high. It stays 1 until it is cleared by a write-one in byte lane 1.
- R2: Bits 14:12 show bits 3:1 of `slot12_nib`, taken one cycle after a cycle with `slot12_vld` high. While `slot12_vld` is low these bits hold their value.
- R3: Bits 11 and 10 become 1 one cycle after `resume_evt[1]` or `resume_evt[0]` is high, in that order. Each clears only through a write-one in byte lane 1.
- R4: Bits 9 and 8 equal `codec_rdy[1]` and `codec_rdy[0]` in the same cycle.
- R5: The live summary bits follow their inputs in the same cycle: bit 7 `int_mic_in`, bit 6 `int_pcm_out`, bit 5 `int_pcm_in`, bit 2 `int_modem_out`, bit 1 `int_modem_in`.
- R6: Bit 0 becomes 1 one cycle after a cycle with `slot12_vld` high and `slot12_nib[0]` high. It clears through a write-one in byte lane 0.
- R7: A low `pwr_rst_n` clears bits 14:12 and leaves bits 15, 11, 10 and 0 unchanged. A low `rst_n` clears every stored bit.
- R8: A write with `bus_xdw` high changes no bit.
- R9: The following have no effect: writing 0, writing 1 to a read-only or reserved bit, and writing 1 in a lane whose `bus_be` bit is 0 (bit 0 of `bus_be` covers status bits 7:0, bit 1 covers 15:8). Bits 4:3 always read 0.
- R10: When an event and a software clear hit the same event bit in the same cycle, the bit reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Main synchronous reset, active low |
| pwr_rst_n | input | 1 | Power-state-return synchronous reset, active low |
| rd_timeout | input | 1 | Codec read time-out pulse |
| resume_evt | input | 2 | Resume event pulses, one per serial data input |
| codec_rdy | input | 2 | Codec-ready levels, one per serial data input |
| slot12_nib | input | 4 | Low nibble of the received slot 12 |
| slot12_vld | input | 1 | Strobe marking `slot12_nib` valid |
| int_mic_in | input | 1 | Mic-in channel interrupt summary |
| int_pcm_out | input | 1 | PCM-out channel interrupt summary |
| int_pcm_in | input | 1 | PCM-in channel interrupt summary |
| int_modem_out | input | 1 | Modem-out channel interrupt summary |
| int_modem_in | input | 1 | Modem-in channel interrupt summary |
| bus_wr | input | 1 | Register write strobe |
| bus_xdw | input | 1 | Access crosses a 32-bit boundary |
| bus_be | input | 2 | Byte lane enables |
| bus_wdata | input | 16 | Write data, a 1 clears the event bit |
| status | output | 16 | Status word read value |

## Verification
The bench sweeps every combination of the live inputs and every slot 12 nibble. A design that registered the live bits, or that updated the slot copy without a strobe, would show stale values. Write-one clears are tried with a zero write, with the wrong byte lane and with a boundary-crossing write, so that each kind of ignored write is covered. A design that decoded any of them would lose a sticky bit. The bench makes an event and a clear land in the same cycle, which catches a clear-over-set priority. It applies both resets to a fully set word, which exposes a power-return reset that wipes the sticky bits.

// File: rtl/glsts_pkg.sv
package glsts_pkg;
    localparam int REG_W      = 16;
    localparam int BE_W       = REG_W / 8;
    localparam int N_SDIN     = 2;
    localparam int NIB_W      = 4;
    localparam int DISP_W     = NIB_W - 1;

    // bit positions decoded by software
    localparam int P_RCS      = 15;
    localparam int P_DISP_LO  = 12;
    localparam int P_RES_LO   = 10;
    localparam int P_RDY_LO   = 8;
    localparam int P_MIC      = 7;
    localparam int P_PCMO     = 6;
    localparam int P_PCMI     = 5;
    localparam int P_MDMO     = 2;
    localparam int P_MDMI     = 1;
    localparam int P_GPI      = 0;

    localparam int N_STICKY   = 4;

    // position of each sticky bit, index order gpi, res0, res1, rcs
    function automatic int sticky_pos(input int k);
        case (k)
            0:       return P_GPI;
            1:       return P_RES_LO;
            2:       return P_RES_LO + 1;
            default: return P_RCS;
        endcase
    endfunction

    localparam logic [REG_W-1:0] W1C_BITS =
        (REG_W'(1) << P_RCS) | (REG_W'(3) << P_RES_LO) | (REG_W'(1) << P_GPI);
endpackage

// File: rtl/glsts_w1c_bit.sv
module glsts_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;   // event beats software clear
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/glsts_wr_decode.sv
module glsts_wr_decode
    import glsts_pkg::*;
(
    input  logic             bus_wr,
    input  logic             bus_xdw,
    input  logic [BE_W-1:0]  bus_be,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] clr_mask
);
    logic wr_ok;
    assign wr_ok = bus_wr && !bus_xdw;

    for (genvar i = 0; i < REG_W; i++) begin : g_lane
        assign clr_mask[i] = wr_ok && bus_be[i/8] && bus_wdata[i] && W1C_BITS[i];
    end
endmodule

// File: rtl/glsts_slot_cap.sv
module glsts_slot_cap
    import glsts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_rst_n,
    input  logic              vld,
    input  logic [NIB_W-1:0]  nib,
    output logic [DISP_W-1:0] disp,
    output logic              gpi_set
);
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_rst_n) disp <= '0;
        else if (vld)             disp <= nib[NIB_W-1:1];
    end

    assign gpi_set = vld && nib[0];
endmodule

// File: rtl/glsts_status.sv
module glsts_status
    import glsts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_rst_n,
    input  logic              rd_timeout,
    input  logic [N_SDIN-1:0] resume_evt,
    input  logic [N_SDIN-1:0] codec_rdy,
    input  logic [NIB_W-1:0]  slot12_nib,
    input  logic              slot12_vld,
    input  logic              int_mic_in,
    input  logic              int_pcm_out,
    input  logic              int_pcm_in,
    input  logic              int_modem_out,
    input  logic              int_modem_in,
    input  logic              bus_wr,
    input  logic              bus_xdw,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  status
);
    logic [REG_W-1:0]    clr_mask;
    logic [DISP_W-1:0]   disp;
    logic                gpi_set;
    logic [N_STICKY-1:0] set_vec;
    logic [N_STICKY-1:0] sticky_q;

    glsts_wr_decode u_dec (
        .bus_wr    (bus_wr),
        .bus_xdw   (bus_xdw),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .clr_mask  (clr_mask)
    );

    glsts_slot_cap u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_rst_n (pwr_rst_n),
        .vld       (slot12_vld),
        .nib       (slot12_nib),
        .disp      (disp),
        .gpi_set   (gpi_set)
    );

    assign set_vec = {rd_timeout, resume_evt[1], resume_evt[0], gpi_set};

    // sticky bits use the main reset only
    for (genvar k = 0; k < N_STICKY; k++) begin : g_sticky
        glsts_w1c_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_vec[k]),
            .clr   (clr_mask[sticky_pos(k)]),
            .q     (sticky_q[k])
        );
    end

    always_comb begin
        status = '0;
        for (int k = 0; k < N_STICKY; k++) status[sticky_pos(k)] = sticky_q[k];
        status[P_DISP_LO +: DISP_W] = disp;
        status[P_RDY_LO  +: N_SDIN] = codec_rdy;
        status[P_MIC]  = int_mic_in;
        status[P_PCMO] = int_pcm_out;
        status[P_PCMI] = int_pcm_in;
        status[P_MDMO] = int_modem_out;
        status[P_MDMI] = int_modem_in;
    end
endmodule

// File: rtl/glsts_checker.sv
module glsts_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pwr_rst_n,
    input logic        rd_timeout,
    input logic [1:0]  resume_evt,
    input logic [1:0]  codec_rdy,
    input logic [3:0]  slot12_nib,
    input logic        slot12_vld,
    input logic        bus_wr,
    input logic        bus_xdw,
    input logic [1:0]  bus_be,
    input logic [15:0] bus_wdata,
    input logic [15:0] status
);
    a_r1_timeout_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rd_timeout |=> status[15]);

    a_r2_disp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot12_vld && pwr_rst_n) |=> $stable(status[14:12]));

    a_r2_disp_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (slot12_vld && pwr_rst_n) |=> status[14:12] == $past(slot12_nib[3:1]));

    a_r3_resume_sets: assert property (@(posedge clk) disable iff (!rst_n)
        resume_evt[0] |=> status[10]);

    a_r4_ready_live: assert property (@(posedge clk) disable iff (!rst_n)
        status[9:8] == codec_rdy);

    a_r6_gpi_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (slot12_vld && slot12_nib[0]) |=> status[0]);

    a_r7_pwr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_rst_n && !bus_wr) |=> status[15] == $past(status[15]));

    a_r8_cross_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_xdw && status[11]) |=> status[11]);

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[4:3] == 2'b00);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_timeout && bus_wr && !bus_xdw && bus_be[1] && bus_wdata[15]) |=> status[15]);
endmodule

bind glsts_status glsts_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_rst_n  (pwr_rst_n),
    .rd_timeout (rd_timeout),
    .resume_evt (resume_evt),
    .codec_rdy  (codec_rdy),
    .slot12_nib (slot12_nib),
    .slot12_vld (slot12_vld),
    .bus_wr     (bus_wr),
    .bus_xdw    (bus_xdw),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .status     (status)
);

// File: tb/glsts_status_tb.sv
`timescale 1ns/1ps
module glsts_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, pwr_rst_n = 1'b1;
    logic        rd_timeout = 1'b0;
    logic [1:0]  resume_evt = '0, codec_rdy = '0;
    logic [3:0]  slot12_nib = '0;
    logic        slot12_vld = 1'b0;
    logic        int_mic_in = 1'b0, int_pcm_out = 1'b0, int_pcm_in = 1'b0;
    logic        int_modem_out = 1'b0, int_modem_in = 1'b0;
    logic        bus_wr = 1'b0, bus_xdw = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] status;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    glsts_status u_dut (.*);

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d, input logic x);
        bus_wr = 1'b1; bus_be = be; bus_wdata = d; bus_xdw = x;
        step();
        bus_wr = 1'b0; bus_be = '0; bus_wdata = '0; bus_xdw = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        chk("R7 main reset", status, 16'h0000);
        rst_n = 1'b1; step();

        // R4 R5: all live input combinations
        for (int i = 0; i < 128; i++) begin
            logic [6:0] v;
            v = 7'(i);
            {codec_rdy, int_mic_in, int_pcm_out, int_pcm_in, int_modem_out, int_modem_in} = v;
            #1;
            chk("R4 R5 live bits", status,
                (16'(v[6:5]) << 8) | (16'(v[4:2]) << 5) | (16'(v[1:0]) << 1));
        end
        {codec_rdy, int_mic_in, int_pcm_out, int_pcm_in, int_modem_out, int_modem_in} = '0;

        // R2 R6: every nibble
        for (int n = 0; n < 16; n++) begin
            logic [3:0] nb;
            nb = 4'(n);
            slot12_nib = nb; slot12_vld = 1'b1; step();
            slot12_vld = 1'b0; slot12_nib = ~nb;
            chk("R2 R6 capture", status, (16'(nb[3:1]) << 12) | 16'(nb[0]));
            step();
            chk("R2 hold without strobe", status, (16'(nb[3:1]) << 12) | 16'(nb[0]));
            wr(2'b01, 16'h0001, 1'b0);
            chk("R6 clear", status, 16'(nb[3:1]) << 12);
        end
        slot12_nib = 4'b0000; slot12_vld = 1'b1; step(); slot12_vld = 1'b0;

        // R1 with ignored writes
        rd_timeout = 1'b1; step(); rd_timeout = 1'b0;
        chk("R1 timeout set", status, 16'h8000);
        wr(2'b11, 16'h0000, 1'b0);
        chk("R9 zero write", status, 16'h8000);
        wr(2'b01, 16'hffff, 1'b0);
        chk("R9 wrong lane", status, 16'h8000);
        wr(2'b11, 16'hffff, 1'b1);
        chk("R8 crossing write", status, 16'h8000);
        wr(2'b10, 16'h8000, 1'b0);
        chk("R1 clear", status, 16'h0000);

        // R3 each resume input
        for (int k = 0; k < 2; k++) begin
            resume_evt = 2'(1 << k); step(); resume_evt = '0;
            chk("R3 resume set", status, 16'(1 << (10 + k)));
            wr(2'b10, 16'h0c00, 1'b0);
            chk("R3 resume clear", status, 16'h0000);
        end

        // R9 writes to read-only and reserved bits
        slot12_nib = 4'b1110; slot12_vld = 1'b1; step(); slot12_vld = 1'b0;
        wr(2'b11, 16'h73fe, 1'b0);
        chk("R9 read-only write", status, 16'h7000);

        // R10 set beats clear
        rd_timeout = 1'b1; resume_evt = 2'b10;
        wr(2'b10, 16'h8800, 1'b0);
        rd_timeout = 1'b0; resume_evt = '0;
        chk("R10 set wins", status, 16'hf800);
        wr(2'b10, 16'h8800, 1'b0);

        // R7 power reset keeps sticky bits
        rd_timeout = 1'b1; resume_evt = 2'b11; slot12_nib = 4'b1111; slot12_vld = 1'b1;
        step();
        rd_timeout = 1'b0; resume_evt = '0; slot12_vld = 1'b0;
        chk("R7 all set", status, 16'hfc01);
        pwr_rst_n = 1'b0; step(); pwr_rst_n = 1'b1;
        chk("R7 power reset", status, 16'h8c01);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        chk("R7 main reset clears", status, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule